// File: doc/BRIEF.md
# Clock Frequency Select and Gating Controller

This block sits in the control logic of a multi-output clock synthesizer. It picks the 5-bit frequency-table index that the synthesizer uses. It also decides, one output at a time, whether each clock output runs. The PLL, the dividers and the pad drivers sit outside it and take their settings from it.

At the first clock after reset, four frequency-select strap pins are captured. Those values stay fixed until the next reset and can be read back. A software-select bit chooses between two sources for the table index. When the bit is 0, the index is the strap code with a fixed upper bit added. When the bit is 1, the index is a 5-bit software code. A direct divider-programming mode can replace the table. A watchdog guards that mode: any register write restarts the count, and if no write arrives in time the mode switches itself off. The synthesizer then falls back to the table index.

Each clock output has a register enable bit. The enable can be removed by three active-low inputs:
- Power-down stops every output.
- PCI-stop stops the PCI outputs, except the free-running ones.
- CPU-stop stops a CPU output, but only when that output's stop-permit bit is set.

A new run state is taken only while that output's clock is in its low phase. This prevents runt pulses. A separate tri-state bit requests high impedance on every output.

Top module: `clk_sel_gate`

## Requirements
- R1: `strap_q` takes the value of `strap_fs` at the first rising clock edge after `rst_n` is released. After that it does not change until the next reset, even across power-down.
- R2: `tbl_idx` is `sw_code` when `sw_sel_en` is 1. When `sw_sel_en` is 0, it is {`HW_MSB`, `strap_q`}, with `strap_q` in bits 3:0. The value follows the inputs in the same cycle.
- R3: A `dp_wr` with `dp_wdata`=1 sets `dp_active` at the next edge. A `dp_wr` with `dp_wdata`=0 clears it at the next edge.
- R4: If no `reg_wr` or `dp_wr` arrives, `dp_active` stays 1 for exactly `WD_LIMIT` cycles after the edge that set it, then clears itself.
- R5: A `reg_wr` while `dp_active` is 1 restarts the count. `dp_active` then stays 1 for `WD_LIMIT` cycles after that write's edge.
- R6: When `pd_n` is 0, every output whose `phase_lo` bit is 1 has `run_en`=0 after the edge, whatever its enable bit.
- R7: When `pci_stop_n` is 0, the stoppable PCI outputs stop and the free-running PCI outputs keep running. Output index layout: CPU outputs are 0..`NUM_CPU`-1. PCI outputs follow, with the `NUM_FREE` free-running ones first. The other outputs come last.
- R8: When `cpu_stop_n` is 0, CPU output i stops only if `cpu_stop_perm[i]` is 1. Otherwise it keeps running.
- R9: With no stop or power-down active, `run_en[i]` follows `out_en_reg[i]`: 1 means run, 0 means stopped.
- R10: `run_en[i]` changes only at an edge where `phase_lo[i]` is 1. At other edges it holds.
- R11: `hiz` equals `tri_all` delayed by one clock.
- R12: While reset is held, `run_en`, `dp_active`, `hiz` and `strap_q` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Control clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| strap_fs | input | 4 | Frequency-select strap pins |
| sw_sel_en | input | 1 | 1 selects the software code for the table index |
| sw_code | input | 5 | Software table code |
| reg_wr | input | 1 | Pulse on any register write; restarts the watchdog |
| dp_wr | input | 1 | Write strobe for the direct-programming enable |
| dp_wdata | input | 1 | Value written to the direct-programming enable |
| tri_all | input | 1 | Request high impedance on all outputs |
| pd_n | input | 1 | Active-low power-down |
| pci_stop_n | input | 1 | Active-low stop for the stoppable PCI outputs |
| cpu_stop_n | input | 1 | Active-low stop for the permitted CPU outputs |
| cpu_stop_perm | input | NUM_CPU | Per-CPU-output stop permit |
| out_en_reg | input | NUM_OUT | Per-output enable bits |
| phase_lo | input | NUM_OUT | 1 while that output's clock is in its low phase |
| strap_q | output | 4 | Latched strap value |
| tbl_idx | output | 5 | Selected frequency-table index |
| dp_active | output | 1 | Direct divider programming in force |
| hiz | output | 1 | All outputs to high impedance |
| run_en | output | NUM_OUT | Gated run enable per output |

## Verification
The hardest case to reach from the ports is the exact cycle in which the watchdog drops direct programming. The case where a `reg_wr` arrives just before that cycle is equally hard. The stimulus enables the mode, keeps both write strobes low for a known number of cycles, and probes `dp_active` one cycle before and one cycle after the expected drop. It then repeats the sequence with a write part way through. A second hard case is a gating change held back by a high clock phase. The bench changes enables and stop pins while `phase_lo` is held low, confirms that `run_en` does not move, and then releases the phase.

// File: rtl/clk_sel_gate_pkg.sv
package clk_sel_gate_pkg;
    localparam int CODE_W  = 5;
    localparam int STRAP_W = 4;

    typedef enum logic [1:0] {
        OC_CPU      = 2'd0,
        OC_PCI_STOP = 2'd1,
        OC_FREE     = 2'd2
    } out_class_e;
endpackage

// File: rtl/fsg_strap_sel.sv
module fsg_strap_sel
    import clk_sel_gate_pkg::*;
#(
    parameter logic HW_MSB = 1'b0
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [STRAP_W-1:0] strap_fs,
    input  logic               sw_sel_en,
    input  logic [CODE_W-1:0]  sw_code,
    output logic [STRAP_W-1:0] strap_q,
    output logic [CODE_W-1:0]  tbl_idx
);
    typedef struct packed {
        logic               taken;
        logic [STRAP_W-1:0] fs;
    } strap_st_t;

    strap_st_t st_d, st_q;

    // R1: capture once on the first edge out of reset
    always_comb begin
        st_d = st_q;
        if (!st_q.taken) begin
            st_d.taken = 1'b1;
            st_d.fs    = strap_fs;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R2: table index source choice
    always_comb begin
        if (sw_sel_en) tbl_idx = sw_code;
        else           tbl_idx = {HW_MSB, st_q.fs};
    end

    assign strap_q = st_q.fs;
endmodule

// File: rtl/fsg_dirprog_wd.sv
module fsg_dirprog_wd #(
    parameter int WD_LIMIT = 1024
) (
    input  logic clk,
    input  logic rst_n,
    input  logic reg_wr,
    input  logic dp_wr,
    input  logic dp_wdata,
    output logic dp_active
);
    localparam int CNT_W = (WD_LIMIT > 2) ? $clog2(WD_LIMIT) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(WD_LIMIT - 1);

    typedef struct packed {
        logic             en;
        logic [CNT_W-1:0] cnt;
    } wd_st_t;

    wd_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (dp_wr) begin
            // R3: explicit write of the enable
            st_d.en  = dp_wdata;
            st_d.cnt = '0;
        end else if (st_q.en) begin
            if (reg_wr) begin
                // R5: any register write reloads
                st_d.cnt = '0;
            end else if (st_q.cnt == LAST) begin
                // R4: timeout drops the mode
                st_d.en  = 1'b0;
                st_d.cnt = '0;
            end else begin
                st_d.cnt = st_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign dp_active = st_q.en;
endmodule

// File: rtl/fsg_gate_bank.sv
module fsg_gate_bank
    import clk_sel_gate_pkg::*;
#(
    parameter int NUM_CPU  = 2,
    parameter int NUM_PCI  = 8,
    parameter int NUM_FREE = 2,
    parameter int NUM_MISC = 11,
    localparam int NUM_OUT = NUM_CPU + NUM_PCI + NUM_MISC
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               pd_n,
    input  logic               pci_stop_n,
    input  logic               cpu_stop_n,
    input  logic [NUM_CPU-1:0] cpu_stop_perm,
    input  logic [NUM_OUT-1:0] out_en_reg,
    input  logic [NUM_OUT-1:0] phase_lo,
    input  logic               tri_all,
    output logic [NUM_OUT-1:0] run_en,
    output logic               hiz
);
    typedef struct packed {
        logic               hiz;
        logic [NUM_OUT-1:0] run;
    } gate_st_t;

    gate_st_t st_d, st_q;
    logic [NUM_OUT-1:0] want;

    for (genvar i = 0; i < NUM_OUT; i++) begin : g_out
        localparam out_class_e CLS =
            (i < NUM_CPU)                       ? OC_CPU :
            (i < NUM_CPU + NUM_FREE)            ? OC_FREE :
            (i < NUM_CPU + NUM_PCI)             ? OC_PCI_STOP : OC_FREE;
        logic stop;
        if (CLS == OC_CPU) begin : g_cpu
            // R8: stop only with permit
            assign stop = !cpu_stop_n && cpu_stop_perm[i];
        end else if (CLS == OC_PCI_STOP) begin : g_pci
            // R7: stoppable PCI group
            assign stop = !pci_stop_n;
        end else begin : g_free
            assign stop = 1'b0;
        end
        // R6 / R9: power-down overrides the enable bit
        assign want[i] = pd_n && out_en_reg[i] && !stop;
    end

    always_comb begin
        st_d     = st_q;
        st_d.hiz = tri_all;                           // R11
        for (int k = 0; k < NUM_OUT; k++) begin
            if (phase_lo[k]) st_d.run[k] = want[k];  // R10
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;                       // R12
        else        st_q <= st_d;
    end

    assign run_en = st_q.run;
    assign hiz    = st_q.hiz;
endmodule

// File: rtl/clk_sel_gate.sv
module clk_sel_gate
    import clk_sel_gate_pkg::*;
#(
    parameter int   NUM_CPU  = 2,
    parameter int   NUM_PCI  = 8,
    parameter int   NUM_FREE = 2,
    parameter int   NUM_MISC = 11,
    parameter int   WD_LIMIT = 1024,
    parameter logic HW_MSB   = 1'b0,
    localparam int  NUM_OUT  = NUM_CPU + NUM_PCI + NUM_MISC
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [3:0]         strap_fs,
    input  logic               sw_sel_en,
    input  logic [4:0]         sw_code,
    input  logic               reg_wr,
    input  logic               dp_wr,
    input  logic               dp_wdata,
    input  logic               tri_all,
    input  logic               pd_n,
    input  logic               pci_stop_n,
    input  logic               cpu_stop_n,
    input  logic [NUM_CPU-1:0] cpu_stop_perm,
    input  logic [NUM_OUT-1:0] out_en_reg,
    input  logic [NUM_OUT-1:0] phase_lo,
    output logic [3:0]         strap_q,
    output logic [4:0]         tbl_idx,
    output logic               dp_active,
    output logic               hiz,
    output logic [NUM_OUT-1:0] run_en
);
    fsg_strap_sel #(.HW_MSB(HW_MSB)) u_sel (
        .clk(clk), .rst_n(rst_n), .strap_fs(strap_fs),
        .sw_sel_en(sw_sel_en), .sw_code(sw_code),
        .strap_q(strap_q), .tbl_idx(tbl_idx)
    );

    fsg_dirprog_wd #(.WD_LIMIT(WD_LIMIT)) u_wd (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr),
        .dp_wr(dp_wr), .dp_wdata(dp_wdata), .dp_active(dp_active)
    );

    fsg_gate_bank #(
        .NUM_CPU(NUM_CPU), .NUM_PCI(NUM_PCI),
        .NUM_FREE(NUM_FREE), .NUM_MISC(NUM_MISC)
    ) u_gate (
        .clk(clk), .rst_n(rst_n), .pd_n(pd_n), .pci_stop_n(pci_stop_n),
        .cpu_stop_n(cpu_stop_n), .cpu_stop_perm(cpu_stop_perm),
        .out_en_reg(out_en_reg), .phase_lo(phase_lo), .tri_all(tri_all),
        .run_en(run_en), .hiz(hiz)
    );
endmodule

// File: rtl/clk_sel_gate_chk.sv
module clk_sel_gate_chk #(
    parameter int NUM_CPU  = 2,
    parameter int NUM_FREE = 2,
    parameter int NUM_OUT  = 21,
    parameter int WD_LIMIT = 1024
) (
    input logic               clk,
    input logic               rst_n,
    input logic [3:0]         strap_q,
    input logic               reg_wr,
    input logic               dp_wr,
    input logic               dp_wdata,
    input logic               dp_active,
    input logic               tri_all,
    input logic               hiz,
    input logic               pd_n,
    input logic               pci_stop_n,
    input logic               cpu_stop_n,
    input logic [NUM_CPU-1:0] cpu_stop_perm,
    input logic [NUM_OUT-1:0] out_en_reg,
    input logic [NUM_OUT-1:0] phase_lo,
    input logic [NUM_OUT-1:0] run_en
);
    localparam int FREE_IDX = NUM_CPU;
    localparam int STOP_IDX = NUM_CPU + NUM_FREE;

    logic        seen;
    logic [31:0] quiet_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seen      <= 1'b0;
            quiet_cnt <= '0;
        end else begin
            seen <= 1'b1;
            if (reg_wr || dp_wr)  quiet_cnt <= '0;
            else if (dp_active)   quiet_cnt <= quiet_cnt + 1;
            else                  quiet_cnt <= '0;
        end
    end

    // R1
    strap_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        seen |=> $stable(strap_q));

    // R3
    dp_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dp_wr && dp_wdata) |=> dp_active);

    // R4
    wd_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dp_active |-> (quiet_cnt < WD_LIMIT));

    // R11
    hiz_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (hiz == $past(tri_all)));

    // R10
    phase_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (((run_en ^ $past(run_en)) & ~$past(phase_lo)) == '0));

    // R6
    pd_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !pd_n |=> ((run_en & $past(phase_lo)) == '0));

    // R9
    en_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((run_en & $past(phase_lo) & ~$past(out_en_reg)) == '0));

    // R7
    free_pci_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pd_n && !pci_stop_n && out_en_reg[FREE_IDX] && phase_lo[FREE_IDX])
        |=> run_en[FREE_IDX]);

    // R7
    stop_pci_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!pci_stop_n && phase_lo[STOP_IDX]) |=> !run_en[STOP_IDX]);

    for (genvar c = 0; c < NUM_CPU; c++) begin : g_cpu_chk
        // R8
        cpu_noperm_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (pd_n && !cpu_stop_n && !cpu_stop_perm[c] && out_en_reg[c] && phase_lo[c])
            |=> run_en[c]);
        // R8
        cpu_perm_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (!cpu_stop_n && cpu_stop_perm[c] && phase_lo[c]) |=> !run_en[c]);
    end
endmodule

bind clk_sel_gate clk_sel_gate_chk #(
    .NUM_CPU(NUM_CPU), .NUM_FREE(NUM_FREE),
    .NUM_OUT(NUM_OUT), .WD_LIMIT(WD_LIMIT)
) u_chk (
    .clk(clk), .rst_n(rst_n), .strap_q(strap_q), .reg_wr(reg_wr),
    .dp_wr(dp_wr), .dp_wdata(dp_wdata), .dp_active(dp_active),
    .tri_all(tri_all), .hiz(hiz), .pd_n(pd_n), .pci_stop_n(pci_stop_n),
    .cpu_stop_n(cpu_stop_n), .cpu_stop_perm(cpu_stop_perm),
    .out_en_reg(out_en_reg), .phase_lo(phase_lo), .run_en(run_en)
);

// File: tb/clk_sel_gate_test.sv
module clk_sel_gate_test;
    localparam int NC = 2, NP = 8, NF = 2, NM = 11;
    localparam int NO = NC + NP + NM;
    localparam int LIM = 20;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [3:0] strap_fs = 4'b1010;
    logic sw_sel_en = 1'b0;
    logic [4:0] sw_code = '0;
    logic reg_wr = 1'b0, dp_wr = 1'b0, dp_wdata = 1'b0, tri_all = 1'b0;
    logic pd_n = 1'b1, pci_stop_n = 1'b1, cpu_stop_n = 1'b1;
    logic [NC-1:0] cpu_stop_perm = '1;
    logic [NO-1:0] out_en_reg = '1;
    logic [NO-1:0] phase_lo = '1;
    logic [3:0] strap_q;
    logic [4:0] tbl_idx;
    logic dp_active, hiz;
    logic [NO-1:0] run_en;

    int errors = 0, checks = 0;
    int phase_mode = 0;   // 0: all low phase, 1: random, 2: all high phase
    bit done = 0;

    // reference model state
    logic [3:0]    m_strap = '0;
    bit            m_taken = 0;
    bit            m_dp = 0;
    int            m_quiet = 0;
    bit            m_hiz = 0;
    logic [NO-1:0] m_run = '0;

    always #5 clk = ~clk;

    clk_sel_gate #(.NUM_CPU(NC), .NUM_PCI(NP), .NUM_FREE(NF), .NUM_MISC(NM),
                   .WD_LIMIT(LIM), .HW_MSB(1'b0)) uut (
        .clk(clk), .rst_n(rst_n), .strap_fs(strap_fs), .sw_sel_en(sw_sel_en),
        .sw_code(sw_code), .reg_wr(reg_wr), .dp_wr(dp_wr), .dp_wdata(dp_wdata),
        .tri_all(tri_all), .pd_n(pd_n), .pci_stop_n(pci_stop_n),
        .cpu_stop_n(cpu_stop_n), .cpu_stop_perm(cpu_stop_perm),
        .out_en_reg(out_en_reg), .phase_lo(phase_lo), .strap_q(strap_q),
        .tbl_idx(tbl_idx), .dp_active(dp_active), .hiz(hiz), .run_en(run_en)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic bit wants(input int i);
        bit stop;
        stop = 0;
        if (i < NC) stop = !cpu_stop_n && cpu_stop_perm[i];
        else if (i >= NC + NF && i < NC + NP) stop = !pci_stop_n;
        return pd_n && out_en_reg[i] && !stop;
    endfunction

    // behavioural reference, updated at each rising edge
    always @(posedge clk) begin
        if (!rst_n) begin
            m_strap = '0; m_taken = 0; m_dp = 0; m_quiet = 0; m_hiz = 0; m_run = '0;
        end else begin
            if (!m_taken) begin m_strap = strap_fs; m_taken = 1; end
            m_hiz = tri_all;
            if (dp_wr) begin
                m_dp = dp_wdata; m_quiet = 0;
            end else if (m_dp) begin
                if (reg_wr) m_quiet = 0;
                else begin
                    m_quiet++;
                    if (m_quiet >= LIM) begin m_dp = 0; m_quiet = 0; end
                end
            end
            for (int i = 0; i < NO; i++)
                if (phase_lo[i]) m_run[i] = wants(i);
        end
    end

    always @(negedge clk) begin
        if (phase_mode == 0)      phase_lo <= '1;
        else if (phase_mode == 2) phase_lo <= '0;
        else                      phase_lo <= NO'({$urandom, $urandom});
    end

    // per-cycle comparison, away from both edges
    always @(negedge clk) begin
        #2;
        if (!done) begin
            check("R2", 32'(tbl_idx), 32'(sw_sel_en ? sw_code : {1'b0, m_strap}));
            check("R1", 32'(strap_q), 32'(m_strap));
            check("R3", 32'(dp_active), 32'(m_dp));
            check("R11", 32'(hiz), 32'(m_hiz));
            check("R10", 32'(run_en), 32'(m_run));
        end
    end

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic probe();
        #3;
    endtask

    initial begin
        step(3);
        probe();
        // R12: state under reset
        check("R12", 32'({run_en, dp_active, hiz, strap_q}), 32'h0);
        rst_n = 1'b1;
        step(2);
        strap_fs = 4'b0101;      // must not be taken (R1)
        step(1); probe();
        check("R1", 32'(strap_q), 32'hA);
        check("R2", 32'(tbl_idx), 32'h0A);

        // R2: software codes
        sw_sel_en = 1'b1; sw_code = 5'd31; step(1); probe();
        check("R2", 32'(tbl_idx), 32'd31);
        sw_code = 5'd17; step(1); probe();
        check("R2", 32'(tbl_idx), 32'd17);
        sw_sel_en = 1'b0; step(1);

        // R9: enable pattern with all phases low
        out_en_reg = NO'(21'h15A5C3); step(2); probe();
        check("R9", 32'(run_en), 32'h15A5C3);
        out_en_reg = '1; step(2); probe();
        check("R9", 32'(run_en), 32'h1FFFFF);

        // R8: cpu stop with partial permit
        cpu_stop_perm = 2'b01; cpu_stop_n = 1'b0; step(2); probe();
        check("R8", 32'(run_en[1:0]), 32'h2);
        cpu_stop_perm = 2'b10; step(2); probe();
        check("R8", 32'(run_en[1:0]), 32'h1);
        cpu_stop_perm = 2'b00; step(2); probe();
        check("R8", 32'(run_en[1:0]), 32'h3);
        cpu_stop_n = 1'b1; cpu_stop_perm = 2'b11;

        // R7: pci stop spares the free-running pair
        pci_stop_n = 1'b0; step(2); probe();
        check("R7", 32'(run_en[NC+NP-1:NC]), 32'h03);
        check("R7", 32'(run_en[NO-1:NC+NP]), 32'h7FF);
        pci_stop_n = 1'b1; step(2);

        // R10: high phase holds the old state
        phase_mode = 2; step(1);
        out_en_reg = '0; pd_n = 1'b0; step(3); probe();
        check("R10", 32'(run_en), 32'h1FFFFF);
        phase_mode = 0; step(2); probe();
        // R6: power-down stops everything
        out_en_reg = '1; step(2); probe();
        check("R6", 32'(run_en), 32'h0);
        strap_fs = 4'b1111;
        pd_n = 1'b1; step(2); probe();
        check("R1", 32'(strap_q), 32'hA);
        check("R6", 32'(run_en), 32'h1FFFFF);

        // R11: tri-state
        tri_all = 1'b1; step(1); probe();
        check("R11", 32'(hiz), 32'h1);
        tri_all = 1'b0; step(1);

        // R3 / R4: set, then let the watchdog expire
        dp_wr = 1'b1; dp_wdata = 1'b1; step(1);
        dp_wr = 1'b0; probe();
        check("R3", 32'(dp_active), 32'h1);
        step(LIM - 1); probe();
        check("R4", 32'(dp_active), 32'h1);
        step(1); probe();
        check("R4", 32'(dp_active), 32'h0);

        // R5: reload by a register write
        dp_wr = 1'b1; step(1); dp_wr = 1'b0;
        step(10);
        reg_wr = 1'b1; step(1); reg_wr = 1'b0;
        step(LIM - 1); probe();
        check("R5", 32'(dp_active), 32'h1);
        step(1); probe();
        check("R5", 32'(dp_active), 32'h0);

        // R3: explicit clear
        dp_wr = 1'b1; step(1); dp_wdata = 1'b0; step(1); dp_wr = 1'b0; probe();
        check("R3", 32'(dp_active), 32'h0);

        // mixed random phases and stops, model compared every cycle
        phase_mode = 1;
        for (int k = 0; k < 300; k++) begin
            pd_n       = ($urandom % 8) != 0;
            pci_stop_n = ($urandom % 3) != 0;
            cpu_stop_n = ($urandom % 3) != 0;
            cpu_stop_perm = NC'($urandom);
            out_en_reg = NO'({$urandom, $urandom});
            reg_wr     = ($urandom % 16) == 0;
            dp_wr      = ($urandom % 40) == 0;
            dp_wdata   = $urandom % 2;
            tri_all    = ($urandom % 5) == 0;
            sw_sel_en  = $urandom % 2;
            sw_code    = 5'($urandom);
            step(1);
        end
        step(2);
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #1000000;
        errors++;
        checks++;
        $display("FAIL watchdog: actual=hung expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule